// File: doc/BRIEF.md
# Training-State Link Readiness Poller

This block decides whether a serial link is ready for traffic by watching the training-state field that the link core exposes in a wider debug status word. A single-cycle start request begins a check. The block samples the state code right away. If the link is not yet up, it samples again once per poll interval. The interval is counted in pulses of a free-running millisecond tick. The check ends at the first sample that shows an operational state, or after a bounded number of samples that all show the link down.

A one-cycle done pulse reports the end of each check. The result bit is valid in that same cycle and keeps its value until the next start is accepted. Three codes count as up: 0x11 (fully active), 0x12 (active standby) and 0x14 (light sleep idle). Every other code counts as down, including the deep-sleep codes 0x15 and 0x16. The defaults are one tick per poll and 120 polls, which bound a check at 120 ms.

Top module: `link_watch`

## Requirements
- R1: While reset is asserted and after it is released, `done_o` and `link_up_o` are 0 until a check completes.
- R2: Only bits [4:0] of `train_status_i` are decoded. The remaining bits of the word have no effect on the result or on the timing of the check.
- R3: Codes 0x11, 0x12 and 0x14 count as link up. Every other 5-bit code counts as link down, including 0x15 and 0x16.
- R4: The first sample is taken at the clock edge that accepts `start_i`. Each later sample is taken at the edge where every TICKS_PER_POLL-th `ms_tick_i` pulse is seen during the check. A tick in the accepting cycle, or while idle, does not count.
- R5: `done_o` rises in the cycle after the sample that ends a check and stays high for exactly one cycle.
- R6: The first sample that shows an up code ends the check, with `link_up_o` = 1.
- R7: When MAX_POLLS consecutive samples all show a down code, the check ends with `link_up_o` = 0. With the defaults, this comes 119 counted ticks after the accepting edge.
- R8: `link_up_o` keeps its value from the end of a check until the next accepted start. Accepting a start drives it to 0, unless the first sample already shows an up code.
- R9: A `start_i` pulse that arrives while a check is running is ignored. It neither restarts nor extends the check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ms_tick_i | input | 1 | One-cycle pulse, once per millisecond |
| train_status_i | input | DBG_W | Debug status word; bits [4:0] hold the training state |
| start_i | input | 1 | One-cycle request to begin a check |
| done_o | output | 1 | One-cycle pulse at the end of a check |
| link_up_o | output | 1 | Result of the last completed check |

## Verification
The checker assumes that `start_i` and `ms_tick_i` are synchronous to `clk`, are single-cycle pulses, and that the status word is stable around each clock edge. The result properties rely on that stability, because they compare the result with the code that was present one edge earlier. The bench drives every input on the falling edge, which keeps codes stable across each sampling edge. It spaces ticks several cycles apart and includes a deliberate second start during a running check, so that the ignore rule is exercised without breaking the pulse assumptions.

// File: rtl/link_watch_pkg.sv
package link_watch_pkg;

   localparam int CODE_W = 5;

   localparam logic [CODE_W-1:0] CODE_ACTIVE      = 5'h11;
   localparam logic [CODE_W-1:0] CODE_STANDBY     = 5'h12;
   localparam logic [CODE_W-1:0] CODE_LIGHT_SLEEP = 5'h14;

   function automatic logic is_link_up(input logic [CODE_W-1:0] code);
      return (code == CODE_ACTIVE) || (code == CODE_STANDBY) ||
             (code == CODE_LIGHT_SLEEP);
   endfunction

endpackage

// File: rtl/lw_decode.sv
module lw_decode
   import link_watch_pkg::*;
(
   input  logic [CODE_W-1:0] code_i,
   output logic              up_o
);

   always_comb begin
      up_o = is_link_up(code_i);
   end

endmodule

// File: rtl/lw_interval.sv
module lw_interval #(
   parameter int TICKS = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic tick_i,
   output logic due_o
);

   generate
      if (TICKS == 1) begin : g_direct
         logic unused_clk_rst;
         assign unused_clk_rst = clk ^ rst_n;
         assign due_o = run_i & tick_i;
      end else begin : g_count
         localparam int TW = $clog2(TICKS);
         localparam logic [TW-1:0] LAST_TICK = TW'(TICKS - 1);
         logic [TW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (!run_i) begin
               cnt_q <= '0;
            end else if (tick_i) begin
               cnt_q <= (cnt_q == LAST_TICK) ? '0 : cnt_q + 1'b1;
            end
         end

         assign due_o = run_i & tick_i & (cnt_q == LAST_TICK);
      end
   endgenerate

endmodule

// File: rtl/lw_seq.sv
module lw_seq #(
   parameter int MAX_POLLS = 120,
   parameter int CNT_W     = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             due_i,
   input  logic             code_up_i,
   output logic             busy_o,
   output logic             sample_o,
   output logic [CNT_W-1:0] poll_cnt_o,
   output logic             done_o,
   output logic             up_o
);

   localparam logic [CNT_W-1:0] LAST_POLL = CNT_W'(MAX_POLLS - 1);

   logic             busy_q;
   logic             done_q;
   logic             up_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] polls_now;
   logic             sample;

   assign sample    = busy_q ? due_i : start_i;
   assign polls_now = busy_q ? cnt_q : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         up_q   <= 1'b0;
         cnt_q  <= '0;
      end else begin
         done_q <= 1'b0;
         if (sample) begin
            if (code_up_i) begin
               done_q <= 1'b1;
               up_q   <= 1'b1;
               busy_q <= 1'b0;
               cnt_q  <= '0;
            end else if (polls_now == LAST_POLL) begin
               done_q <= 1'b1;
               up_q   <= 1'b0;
               busy_q <= 1'b0;
               cnt_q  <= '0;
            end else begin
               up_q   <= 1'b0;
               busy_q <= 1'b1;
               cnt_q  <= polls_now + 1'b1;
            end
         end
      end
   end

   assign busy_o     = busy_q;
   assign sample_o   = sample;
   assign poll_cnt_o = cnt_q;
   assign done_o     = done_q;
   assign up_o       = up_q;

endmodule

// File: rtl/link_watch.sv
module link_watch
   import link_watch_pkg::*;
#(
   parameter int DBG_W          = 32,
   parameter int MAX_POLLS      = 120,
   parameter int TICKS_PER_POLL = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ms_tick_i,
   input  logic [DBG_W-1:0] train_status_i,
   input  logic             start_i,
   output logic             done_o,
   output logic             link_up_o
);

   localparam int CNT_W = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;

   generate
      if (MAX_POLLS < 1) begin : g_bad_polls
         $error("link_watch: MAX_POLLS must be at least 1");
      end
      if (TICKS_PER_POLL < 1) begin : g_bad_ticks
         $error("link_watch: TICKS_PER_POLL must be at least 1");
      end
      if (DBG_W < CODE_W) begin : g_bad_width
         $error("link_watch: DBG_W must cover the state field");
      end
      if (DBG_W > CODE_W) begin : g_hi_bits
         logic unused_hi;
         assign unused_hi = ^train_status_i[DBG_W-1:CODE_W];
      end
   endgenerate

   logic             code_up;
   logic             busy;
   logic             due;
   logic             sample_en;
   logic [CNT_W-1:0] poll_cnt;

   lw_decode u_decode (
      .code_i (train_status_i[CODE_W-1:0]),
      .up_o   (code_up)
   );

   lw_interval #(.TICKS(TICKS_PER_POLL)) u_interval (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (busy),
      .tick_i (ms_tick_i),
      .due_o  (due)
   );

   lw_seq #(.MAX_POLLS(MAX_POLLS), .CNT_W(CNT_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .due_i      (due),
      .code_up_i  (code_up),
      .busy_o     (busy),
      .sample_o   (sample_en),
      .poll_cnt_o (poll_cnt),
      .done_o     (done_o),
      .up_o       (link_up_o)
   );

endmodule

// File: rtl/link_watch_chk.sv
module link_watch_chk
   import link_watch_pkg::*;
#(
   parameter int MAX_POLLS = 120,
   parameter int CNT_W     = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic [CODE_W-1:0] code_i,
   input logic              done_o,
   input logic              link_up_o,
   input logic              busy,
   input logic              sample_en,
   input logic [CNT_W-1:0]  poll_cnt
);

   localparam logic [CNT_W-1:0] LAST_POLL = CNT_W'(MAX_POLLS - 1);

   assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_up_from_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && link_up_o) |-> is_link_up($past(code_i)));

   assert_timeout_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !link_up_o) |-> (!is_link_up($past(code_i)) &&
                                  ($past(poll_cnt) == LAST_POLL || MAX_POLLS == 1)));

   assert_poll_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      poll_cnt <= LAST_POLL);

   assert_rise_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(link_up_o) |-> done_o);

   assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start_i) |=> $stable(link_up_o));

   assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start_i && !sample_en) |=> $stable(poll_cnt));

endmodule

bind link_watch link_watch_chk #(.MAX_POLLS(MAX_POLLS), .CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start_i   (start_i),
   .code_i    (train_status_i[link_watch_pkg::CODE_W-1:0]),
   .done_o    (done_o),
   .link_up_o (link_up_o),
   .busy      (busy),
   .sample_en (sample_en),
   .poll_cnt  (poll_cnt)
);

// File: tb/link_watch_tb_top.sv
module link_watch_tb_top;

   localparam int DBG_W    = 32;
   localparam int MAXP     = 120;
   localparam int TPP      = 1;
   localparam int TICK_GAP = 6;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             tick = 1'b0;
   logic             start = 1'b0;
   logic [DBG_W-1:0] status = '0;
   logic             done;
   logic             up;

   always #2 clk = ~clk;

   link_watch #(.DBG_W(DBG_W), .MAX_POLLS(MAXP), .TICKS_PER_POLL(TPP)) dut_i (
      .clk            (clk),
      .rst_n          (rst_n),
      .ms_tick_i      (tick),
      .train_status_i (status),
      .start_i        (start),
      .done_o         (done),
      .link_up_o      (up)
   );

   int    n_chk = 0;
   int    n_fail = 0;
   int    tick_seen = 0;
   bit    tick_en = 1'b0;
   bit    finished = 1'b0;
   string cur_req = "R1";

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
      end
   endtask

   // behavioural reference model
   bit m_busy = 1'b0, m_up = 1'b0, m_done = 1'b0;
   int m_polls = 0, m_ticks = 0;

   always @(posedge clk) begin : ref_model
      bit smp;
      int code;
      if (tick) tick_seen++;
      if (!rst_n) begin
         m_busy = 0; m_up = 0; m_done = 0; m_polls = 0; m_ticks = 0;
      end else begin
         m_done = 0;
         smp = 0;
         if (!m_busy) begin
            if (start) begin
               smp = 1; m_polls = 0; m_ticks = 0; m_up = 0;
            end
         end else if (tick) begin
            m_ticks++;
            if (m_ticks == TPP) begin
               m_ticks = 0;
               smp = 1;
            end
         end
         if (smp) begin
            code = int'(status) & 31;
            if (code == 'h11 || code == 'h12 || code == 'h14) begin
               m_done = 1; m_up = 1; m_busy = 0;
            end else begin
               m_polls++;
               if (m_polls == MAXP) begin
                  m_done = 1; m_up = 0; m_busy = 0;
               end else begin
                  m_busy = 1;
               end
            end
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk("R5", "done vs model", int'(done), int'(m_done));
         chk("R8", "result vs model", int'(up), int'(m_up));
      end
   end

   initial begin : tick_gen
      int k;
      k = 0;
      forever begin
         @(negedge clk);
         k++;
         tick = tick_en && (k % TICK_GAP == 0);
      end
   end

   task automatic pulse_start(output int t0);
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      t0 = tick_seen;
   endtask

   task automatic wait_done(input int t0, output int delta, output bit got_up);
      bit seen;
      seen = 0;
      for (int i = 0; i < 5000 && !seen; i++) begin
         if (done) seen = 1;
         else @(negedge clk);
      end
      if (!seen) chk(cur_req, "done never seen", 0, 1);
      delta  = tick_seen - t0;
      got_up = up;
      @(negedge clk);
      chk("R5", "done drops after one cycle", int'(done), 0);
   endtask

   initial begin : main
      int t0, delta;
      bit got;
      logic [4:0] up_codes [3];
      up_codes[0] = 5'h11; up_codes[1] = 5'h12; up_codes[2] = 5'h14;

      repeat (3) @(negedge clk);
      chk("R1", "done in reset", int'(done), 0);
      chk("R1", "result in reset", int'(up), 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk("R1", "done after reset", int'(done), 0);
      chk("R1", "result after reset", int'(up), 0);
      tick_en = 1'b1;

      // immediate up on each up code
      cur_req = "R6";
      foreach (up_codes[i]) begin
         status = {27'd0, up_codes[i]};
         pulse_start(t0);
         wait_done(t0, delta, got);
         chk("R3", "up code gives result 1", int'(got), 1);
         chk("R4", "first sample at accepting edge", delta, 0);
      end

      // upper bits ignored, low field up
      cur_req = "R2";
      status = 32'hABCD_E0F1;
      pulse_start(t0);
      wait_done(t0, delta, got);
      chk("R2", "upper bits ignored, up", int'(got), 1);
      chk("R2", "upper bits no delay", delta, 0);

      // deep-sleep idle code times out
      cur_req = "R7";
      status = 32'h0000_0015;
      pulse_start(t0);
      wait_done(t0, delta, got);
      chk("R3", "code 0x15 counts as down", int'(got), 0);
      chk("R7", "timeout tick count", delta, MAXP - 1);

      // deep-sleep wake code with upper bits set
      status = 32'h8000_0036;
      pulse_start(t0);
      wait_done(t0, delta, got);
      chk("R3", "code 0x16 counts as down", int'(got), 0);
      chk("R2", "upper bits do not change timeout", delta, MAXP - 1);

      // link comes up after a few polls
      cur_req = "R4";
      status = 32'h0000_0003;
      pulse_start(t0);
      while (tick_seen < t0 + 3) @(negedge clk);
      status = 32'h0000_0011;
      wait_done(t0, delta, got);
      chk("R6", "late up result", int'(got), 1);
      chk("R4", "late up at fourth tick", delta, 4);

      // result held while idle
      cur_req = "R8";
      status = 32'h0000_0015;
      repeat (40) begin
         @(negedge clk);
         if (done) chk("R8", "spurious done while idle", 1, 0);
      end
      chk("R8", "result held while idle", int'(up), 1);
      pulse_start(t0);
      chk("R8", "accepted start clears result", int'(up), 0);
      wait_done(t0, delta, got);
      chk("R7", "timeout after hold test", int'(got), 0);

      // second start during a running check
      cur_req = "R9";
      status = 32'h0000_0002;
      pulse_start(t0);
      repeat (30) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done(t0, delta, got);
      chk("R9", "extra start ignored, tick count", delta, MAXP - 1);
      chk("R9", "extra start ignored, result", int'(got), 0);

      repeat (5) @(negedge clk);
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_fail++;
         $display("FAIL %s watchdog: actual timeout expected completion", cur_req);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule